// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by walking a two-level translation table held in memory. A requester presents an address together with the base of the first-level table. The walker fetches one word descriptor from the first-level table. Depending on that descriptor's type, it either finishes or fetches one more word from a second-level table. It then presents either a physical address or a fault. The memory is reached through a plain read port: a valid/ready request carrying a word address, and a response that carries the data with a valid strobe.

Three mapping sizes coexist in one table. A 1 MiB section is resolved from the first level alone. A 64 KiB large page and a 4 KiB small page are resolved from the second level. A 64 KiB page is described by sixteen identical consecutive second-level entries, so any address inside it finds the same descriptor. The walker handles one translation at a time. It keeps its result on the outputs until the requester takes it.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `res_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk is at `tbl_base + 4 * vaddr[31:20]`, using the base sampled when the request was accepted.
- R3: A first-level descriptor whose bits [1:0] are 0 or 3 ends the walk after one read. The result has `res_fault` = 1 and `res_paddr` = 0. No result with `res_fault` = 1 ever carries a nonzero address.
- R4: A first-level descriptor whose bits [1:0] are 2 ends the walk after one read with `res_paddr = {desc[31:20], vaddr[19:0]}` and `res_fault` = 0.
- R5: A first-level descriptor whose bits [1:0] are 1 causes exactly one more read, at `{desc[31:10], 10'b0} + 4 * vaddr[19:12]`. Descriptor bits [9:2] are ignored.
- R6: A second-level descriptor whose bits [1:0] are 0 gives a fault result (`res_fault` = 1, `res_paddr` = 0).
- R7: A second-level descriptor whose bits [1:0] are 1 is a 64 KiB page: `res_paddr = {desc[31:16], vaddr[15:0]}`. All sixteen entries that make up one such page translate to the same page.
- R8: A second-level descriptor with bit 1 set (bits [1:0] equal to 2 or 3) is a 4 KiB page: `res_paddr = {desc[31:12], vaddr[11:0]}`.
- R9: Only one walk is in flight. `req_ready` drops on the cycle after acceptance and stays 0 until the result has been taken. Requests offered meanwhile are ignored.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_paddr`, `res_fault` and `res_vaddr` hold their values. `res_vaddr` is the accepted request address.
- R11: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` does not change.
- R12: With the memory always ready and responding one cycle after each read is accepted, `res_valid` rises two cycles after acceptance for a one-read walk and four cycles after acceptance for a two-read walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_base | input | 32 | First-level table base address, sampled at acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Requester takes the result |
| res_paddr | output | 32 | Translated address, zero on a fault |
| res_fault | output | 1 | Translation fault |
| res_vaddr | output | 32 | Virtual address this result belongs to |

## Verification
Each result is due a fixed number of edges after acceptance when the memory never stalls: two for a walk that stops at the first level and four for one that goes on to the second level. The bench counts falling edges from acceptance to the first observation of `res_valid` and compares that count with the expected value on every fast-memory walk. On walks with a stalling memory or a slow requester, the bench does not assume a latency. It instead checks at every falling edge that the result holds while it waits. It also checks the read addresses and the read count recorded by its memory model, which are fixed no matter how long the memory stalls.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int AW          = 32;
    localparam int SECT_LSB    = 20;   // first-level index starts here
    localparam int LPAGE_LSB   = 16;
    localparam int SPAGE_LSB   = 12;   // second-level index starts here
    localparam int L2TBL_LSB   = 10;   // second-level tables are 1 KiB aligned
    localparam int L1_IDX_W    = AW - SECT_LSB;
    localparam int L2_IDX_W    = SECT_LSB - SPAGE_LSB;
    localparam int WORD_SHIFT  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        KIND_FAULT,
        KIND_NEXT,
        KIND_LEAF
    } desc_kind_e;

    typedef struct packed {
        desc_kind_e        kind;
        logic [AW-1:0]     addr;   // leaf: physical address, next: table base
    } desc_res_t;

    function automatic logic [AW-1:0] low_mask(input int lsb);
        return (AW'(1) << lsb) - AW'(1);
    endfunction

    function automatic logic [AW-1:0] splice(input logic [AW-1:0] hi_src,
                                             input logic [AW-1:0] lo_src,
                                             input int            lsb);
        return (hi_src & ~low_mask(lsb)) | (lo_src & low_mask(lsb));
    endfunction

    function automatic logic [AW-1:0] l1_offset(input logic [AW-1:0] va);
        return (va >> SECT_LSB) << WORD_SHIFT;
    endfunction

    function automatic logic [AW-1:0] l2_offset(input logic [AW-1:0] va);
        return ((va >> SPAGE_LSB) & low_mask(L2_IDX_W)) << WORD_SHIFT;
    endfunction

endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [AW-1:0] desc,
    input  logic [AW-1:0] va,
    output desc_res_t     res
);

    generate
        if (LEVEL == 1) begin : g_first
            always_comb begin
                res.kind = KIND_FAULT;
                res.addr = '0;
                case (desc[1:0])
                    2'b10: begin
                        res.kind = KIND_LEAF;
                        res.addr = splice(desc, va, SECT_LSB);
                    end
                    2'b01: begin
                        res.kind = KIND_NEXT;
                        res.addr = desc & ~low_mask(L2TBL_LSB);
                    end
                    default: begin
                        res.kind = KIND_FAULT;
                        res.addr = '0;
                    end
                endcase
            end
        end else begin : g_second
            always_comb begin
                res.kind = KIND_FAULT;
                res.addr = '0;
                if (desc[1]) begin
                    res.kind = KIND_LEAF;
                    res.addr = splice(desc, va, SPAGE_LSB);
                end else if (desc[0]) begin
                    res.kind = KIND_LEAF;
                    res.addr = splice(desc, va, LPAGE_LSB);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ptw_desc_addr.sv
module ptw_desc_addr
    import ptw_pkg::*;
(
    input  logic          second,
    input  logic [AW-1:0] l1_base,
    input  logic [AW-1:0] l2_base,
    input  logic [AW-1:0] va,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] first_addr;
    logic [AW-1:0] second_addr;

    always_comb begin
        first_addr  = l1_base + l1_offset(va);
        second_addr = l2_base + l2_offset(va);
        addr        = second ? second_addr : first_addr;
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   tbl_base,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_vaddr,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [31:0]   mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [31:0]   res_paddr,
    output logic          res_fault,
    output logic [31:0]   res_vaddr
);

    walk_state_e   state_q;
    logic [AW-1:0] va_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] l2base_q;
    logic [AW-1:0] pa_q;
    logic          fault_q;

    desc_res_t     l1_res;
    desc_res_t     l2_res;
    desc_res_t     cur_res;
    logic          in_wait;

    ptw_desc_addr i_addr (
        .second  (state_q == ST_L2_REQ),
        .l1_base (base_q),
        .l2_base (l2base_q),
        .va      (va_q),
        .addr    (mem_req_addr)
    );

    ptw_desc_decode #(.LEVEL(1)) i_dec_l1 (
        .desc (mem_rsp_data),
        .va   (va_q),
        .res  (l1_res)
    );

    ptw_desc_decode #(.LEVEL(2)) i_dec_l2 (
        .desc (mem_rsp_data),
        .va   (va_q),
        .res  (l2_res)
    );

    always_comb begin
        cur_res = (state_q == ST_L1_WAIT) ? l1_res : l2_res;
        in_wait = (state_q == ST_L1_WAIT) || (state_q == ST_L2_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            va_q     <= '0;
            base_q   <= '0;
            l2base_q <= '0;
            pa_q     <= '0;
            fault_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        base_q  <= tbl_base;
                        state_q <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ: begin
                    if (mem_req_ready) state_q <= ST_L1_WAIT;
                end
                ST_L2_REQ: begin
                    if (mem_req_ready) state_q <= ST_L2_WAIT;
                end
                ST_L1_WAIT, ST_L2_WAIT: begin
                    if (in_wait && mem_rsp_valid) begin
                        case (cur_res.kind)
                            KIND_LEAF: begin
                                pa_q    <= cur_res.addr;
                                fault_q <= 1'b0;
                                state_q <= ST_DONE;
                            end
                            KIND_NEXT: begin
                                if (state_q == ST_L1_WAIT) begin
                                    l2base_q <= cur_res.addr;
                                    state_q  <= ST_L2_REQ;
                                end else begin
                                    pa_q    <= '0;
                                    fault_q <= 1'b1;
                                    state_q <= ST_DONE;
                                end
                            end
                            default: begin
                                pa_q    <= '0;
                                fault_q <= 1'b1;
                                state_q <= ST_DONE;
                            end
                        endcase
                    end
                end
                ST_DONE: begin
                    if (res_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        res_valid     = (state_q == ST_DONE);
        res_paddr     = pa_q;
        res_fault     = fault_q;
        res_vaddr     = va_q;
    end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        res_valid,
    input logic        res_ready,
    input logic [31:0] res_paddr,
    input logic        res_fault,
    input logic [31:0] res_vaddr
);

    assert_one_walk_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_busy_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && (res_valid || mem_req_valid)));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_paddr) && $stable(res_fault) && $stable(res_vaddr)));

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_fault_no_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault) |-> (res_paddr == 32'h0));

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    assert_no_read_with_result_R9: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_valid && res_valid));

endmodule

bind ptw_walker ptw_walker_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_paddr     (res_paddr),
    .res_fault     (res_fault),
    .res_vaddr     (res_vaddr)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;

    localparam logic [31:0] L1_BASE = 32'h0004_C000;
    localparam logic [31:0] L2_AREA = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] tbl_base;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic        res_ready;
    logic [31:0] res_paddr;
    logic        res_fault;
    logic [31:0] res_vaddr;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;
    bit          slow_mem = 0;
    int          mem_lat  = 0;
    int          tick     = 0;
    int          n_reads  = 0;
    logic [31:0] rd_addr [2];

    always #2 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst(rst), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
        .res_paddr(res_paddr), .res_fault(res_fault), .res_vaddr(res_vaddr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // memory contents as a pure function of address
    function automatic logic [31:0] l1_word(input int i);
        logic [11:0] ix = 12'(i);
        case (ix[1:0])
            2'b10:   return {ix ^ 12'h5A3, 18'h2F0F1, 2'b10};
            2'b01:   return (L2_AREA + 32'(i) * 1024) | ((32'(i) * 3 & 32'hFF) << 2) | 32'h1;
            default: return {ix, 18'h3C3C3, ix[1:0]};
        endcase
    endfunction

    function automatic logic [31:0] l2_word(input int i, input int j);
        logic [11:0] ix = 12'(i);
        logic [7:0]  jx = 8'(j);
        if (jx[5:4] == 2'b01) return {ix[7:0] ^ 8'h3C, jx[7:4], 4'h9, 14'h1555, 2'b01};
        if (!jx[1])           return {jx, ix, 10'h2AA, 2'b00};
        return {ix, jx, 10'h155, jx[1:0]};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a >= L1_BASE && a < L1_BASE + 32'd16384)
            return l1_word(int'((a - L1_BASE) >> 2));
        if (a >= L2_AREA && a < L2_AREA + 32'd4194304)
            return l2_word(int'((a - L2_AREA) >> 10), int'((a >> 2) & 32'hFF));
        return 32'hDEAD_BEE0;
    endfunction

    // memory model
    initial begin
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        @(negedge clk);
        forever begin
            mem_req_ready = slow_mem ? (tick % 3 == 2) : 1'b1;
            tick++;
            if (mem_req_valid && mem_req_ready) begin
                if (n_reads < 2) rd_addr[n_reads] = mem_req_addr;
                n_reads++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (mem_lat) @(negedge clk);
                mem_rsp_data  = mem_word(rd_addr[(n_reads - 1) & 1]);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // one walk: computes expectation from the requirements and checks the result
    task automatic walk(input logic [31:0] va, input bit fast, input int hold,
                        input bit junk);
        logic [31:0] d1, d2, exp_pa, a1, a2;
        bit          exp_f;
        int          exp_reads, cyc;
        string       tag;
        bit          busy_ok;
        logic [31:0] pa0, va0;
        logic        f0;
        a1 = L1_BASE + ((va >> 20) << 2);
        d1 = mem_word(a1);
        a2 = 32'h0;
        exp_reads = 1;
        if (d1[1:0] == 2'b10) begin
            exp_pa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF); exp_f = 0; tag = "R4";
        end else if (d1[1:0] == 2'b01) begin
            exp_reads = 2;
            a2 = (d1 & 32'hFFFF_FC00) + (((va >> 12) & 32'hFF) << 2);
            d2 = mem_word(a2);
            if (d2[1]) begin
                exp_pa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF); exp_f = 0; tag = "R8";
            end else if (d2[0]) begin
                exp_pa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF); exp_f = 0; tag = "R7";
            end else begin
                exp_pa = 0; exp_f = 1; tag = "R6";
            end
        end else begin
            exp_pa = 0; exp_f = 1; tag = "R3";
        end

        n_reads = 0;
        @(negedge clk);
        req_vaddr = va;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (junk) begin
            req_vaddr = ~va;
            tbl_base  = 32'h0;
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0;
        busy_ok = 1;
        while (!res_valid) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        tbl_base  = L1_BASE;
        chk(busy_ok && !req_ready, "R9 busy", {31'b0, req_ready}, 32'h0);
        chk(res_fault == exp_f, tag, {31'b0, res_fault}, {31'b0, exp_f});
        chk(res_paddr == exp_pa, tag, res_paddr, exp_pa);
        chk(res_vaddr == va, "R10 vaddr", res_vaddr, va);
        chk(n_reads == exp_reads, "R3/R5 read count", 32'(n_reads), 32'(exp_reads));
        chk(rd_addr[0] == a1, "R2 first read", rd_addr[0], a1);
        if (exp_reads == 2) chk(rd_addr[1] == a2, "R5 second read", rd_addr[1], a2);
        if (fast) chk(cyc == 2 * exp_reads, "R12 latency", 32'(cyc), 32'(2 * exp_reads));
        pa0 = res_paddr; f0 = res_fault; va0 = res_vaddr;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(res_valid && res_paddr == pa0 && res_fault == f0 && res_vaddr == va0,
                "R10 hold", res_paddr, pa0);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        chk(!res_valid && req_ready, "R9 release", {31'b0, res_valid}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        tbl_base  = L1_BASE;
        req_valid = 1'b0;
        req_vaddr = '0;
        res_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !res_valid && !mem_req_valid, "R1 reset",
            {29'b0, req_ready, res_valid, mem_req_valid}, 32'h4);

        // R7: all sixteen entries of one large page (index 1, group 1)
        for (int e = 0; e < 16; e++)
            walk({12'd1, 4'd1, 4'(e), 12'(e * 257)}, 1'b1, 0, 1'b0);

        // R9: new requests offered during a walk are ignored
        walk({12'd2, 20'h12345}, 1'b1, 0, 1'b1);
        walk({12'd5, 8'd34, 12'h777}, 1'b1, 0, 1'b1);

        // sweep over first-level indices, descriptor kinds and memory speeds
        for (int i = 0; i < 4096; i += 5) begin
            for (int k = 0; k < 3; k++) begin
                logic [31:0] va;
                va = {12'(i), 8'((i * 7 + k * 83) & 255), 12'((i * 13 + k * 1031) & 4095)};
                slow_mem = (k == 2);
                mem_lat  = (k == 2) ? (i % 3) : 0;
                walk(va, k != 2, (k == 1) ? 2 : (k == 2 ? 1 : 0), 1'b0);
            end
        end
        slow_mem = 0;
        mem_lat  = 0;

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule